// File: doc/BRIEF.md
# Background Pixel Decoder for Character and Bitmap Display Modes

This block turns the data of one 8-dot display cell into a stream of 4-bit color indices, one per dot clock, for the background layer of a raster video generator. When a cell begins, the fetch logic presents the cell's screen-matrix byte, its 4-bit color attribute nibble, its pattern byte (a glyph row or a bitmap byte), three mode select bits and four background color values, and pulses `cellStart`. The block captures all of these at that edge. It then emits the cell's dots left to right, starting with the most significant pattern bit.

Alongside each color index it drives a foreground flag that a later compositing stage uses for layer priority and collision. The three mode bits (extended-color, bitmap, multicolor) select one of five legal decodings. In multicolor text, each cell picks its own decoding from its color attribute. The three combinations that pair extended-color with bitmap or multicolor are illegal and paint every dot black (index 0). Fetching, scrolling and sprites are handled elsewhere.

Top module: `bgPixelDecoder`

## Requirements
- R1: After reset, and until the first `cellStart`, `pixColor` is 0 and `pixFg` is 0.
- R2: The block captures all cell inputs (matrix byte, color nibble, pattern byte, mode bits, background colors) on the rising edge where `cellStart` is 1. Dot i (i = 0 for the pattern MSB) appears after the i-th following edge. Inputs changing between `cellStart` pulses have no effect. If no new cell starts after the pattern is used up, the dots that follow decode as all-zero pattern bits.
- R3: Standard text (extended, bitmap, multicolor = 0,0,0): a set pattern bit gives the color nibble; a clear bit gives background 0.
- R4: Multicolor text (0,0,1) with color nibble bit 3 set: each bit pair selects a color. 00 gives background 0, 01 gives background 1, 10 gives background 2, and 11 gives {0, nibble[2:0]}.
- R5: Multicolor text (0,0,1) with color nibble bit 3 clear decodes one bit per dot exactly as in R3.
- R6: Extended-color text (1,0,0): a set bit gives the color nibble; a clear bit gives background k, where k = matrix byte bits [7:6]. The background colors are packed with background k at `bgColors[4k+3:4k]`.
- R7: Hi-res bitmap (0,1,0): a set bit gives matrix byte bits [7:4]; a clear bit gives matrix byte bits [3:0].
- R8: Multicolor bitmap (0,1,1): bit pair 00 gives background 0, 01 gives matrix bits [7:4], 10 gives matrix bits [3:0], and 11 gives the color nibble.
- R9: Any mode with the extended bit set together with the bitmap or multicolor bit (1,0,1 / 1,1,0 / 1,1,1) outputs color 0 on every dot.
- R10: In pair-decoded cells, each 2-bit code is held for two consecutive dots. Pairs are aligned to the cell start, so dots 2j and 2j+1 both show pattern bits [7-2j : 6-2j].
- R11: `pixFg` is 1 for a set bit in one-bit-per-dot cells and for codes 10 and 11 in pair cells. Illegal modes use the same rule, choosing pair or single decoding as if the extended bit were clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cellStart | input | 1 | Capture cell inputs at this edge; dot 0 follows |
| matrixByte | input | 8 | Screen-matrix byte of the cell |
| colorNib | input | 4 | Color attribute nibble of the cell |
| glyphByte | input | 8 | Pattern byte, MSB shown first |
| modeExt | input | 1 | Extended-color mode bit |
| modeBmp | input | 1 | Bitmap mode bit |
| modeMc | input | 1 | Multicolor mode bit |
| bgColors | input | 16 | Four background colors, background k in bits [4k+3:4k] |
| pixColor | output | 4 | Color index of the current dot |
| pixFg | output | 1 | Foreground flag of the current dot |

## Verification
The hardest situations to reach are those where timing and decoding interact: a pair-decoded cell interrupted by the next cell on an odd dot, a cell left running past its eighth dot, and the per-cell switch between pair and single decoding inside multicolor text. Random stimulus varies the cell length between 8 and 10 dots. It draws the color nibble freely, so bit 3 toggles from cell to cell, and draws all eight mode combinations. Directed cells pin down the extended-color background selection for each value of matrix bits [7:6] and the three illegal modes.

// File: rtl/bgdec_pkg.sv
package bgdec_pkg;

  localparam int NUM_BG = 4;

  typedef enum logic [2:0] {
    MODE_STD = 3'd0,
    MODE_MCT = 3'd1,
    MODE_ECT = 3'd2,
    MODE_HBM = 3'd3,
    MODE_MBM = 3'd4,
    MODE_BAD = 3'd5
  } decMode_t;

  typedef struct packed {
    logic     load;
    logic     shiftOne;
    logic     shiftTwo;
    logic     pairMode;
    decMode_t mode;
  } decStrobe_t;

endpackage

// File: rtl/bgDecCtrl.sv
module bgDecCtrl
  import bgdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cellStart,
  input  logic       modeExt,
  input  logic       modeBmp,
  input  logic       modeMc,
  input  logic       nibTop,
  output decStrobe_t strb
);

  decMode_t modeQ;
  decMode_t modeNext;
  logic     pairQ;
  logic     pairNext;
  logic     phaseQ;

  always_comb begin
    unique case ({modeExt, modeBmp, modeMc})
      3'b000:  modeNext = MODE_STD;
      3'b001:  modeNext = MODE_MCT;
      3'b100:  modeNext = MODE_ECT;
      3'b010:  modeNext = MODE_HBM;
      3'b011:  modeNext = MODE_MBM;
      default: modeNext = MODE_BAD;
    endcase
    // pair decoding ignores the extended bit, so illegal modes keep the flag rule
    pairNext = modeMc && (modeBmp || nibTop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_STD;
      pairQ  <= 1'b0;
      phaseQ <= 1'b0;
    end else if (cellStart) begin
      modeQ  <= modeNext;
      pairQ  <= pairNext;
      phaseQ <= 1'b0;
    end else if (pairQ) begin
      phaseQ <= ~phaseQ;
    end
  end

  always_comb begin
    strb.load     = cellStart;
    strb.shiftOne = !cellStart && !pairQ;
    strb.shiftTwo = !cellStart && pairQ && phaseQ;
    strb.pairMode = pairQ;
    strb.mode     = modeQ;
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shiftOne, strb.shiftTwo}));

  p_pair_phase_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pairQ && !cellStart && !phaseQ) |=> phaseQ);

endmodule

// File: rtl/bgColorSel.sv
module bgColorSel
  import bgdec_pkg::*;
#(
  parameter int COLOR_W = 4,
  localparam int MAT_W  = 2 * COLOR_W,
  localparam int BG_W   = NUM_BG * COLOR_W
) (
  input  decMode_t           mode,
  input  logic               pairMode,
  input  logic               hiBit,
  input  logic [1:0]         pairCode,
  input  logic [MAT_W-1:0]   matQ,
  input  logic [COLOR_W-1:0] nibQ,
  input  logic [BG_W-1:0]    bgQ,
  output logic [COLOR_W-1:0] colorOut,
  output logic               fgOut
);

  logic [COLOR_W-1:0] bgArr [NUM_BG];
  logic [COLOR_W-1:0] matHi;
  logic [COLOR_W-1:0] matLo;
  logic [COLOR_W-1:0] nibLow;

  for (genvar g = 0; g < NUM_BG; g++) begin : g_bg
    assign bgArr[g] = bgQ[g*COLOR_W +: COLOR_W];
  end

  assign matHi  = matQ[MAT_W-1 -: COLOR_W];
  assign matLo  = matQ[COLOR_W-1:0];
  assign nibLow = {1'b0, nibQ[COLOR_W-2:0]};

  always_comb begin
    fgOut    = pairMode ? pairCode[1] : hiBit;
    colorOut = '0;
    unique case (mode)
      MODE_STD: colorOut = hiBit ? nibQ : bgArr[0];
      MODE_MCT: begin
        if (!pairMode) colorOut = hiBit ? nibQ : bgArr[0];
        else begin
          unique case (pairCode)
            2'b00: colorOut = bgArr[0];
            2'b01: colorOut = bgArr[1];
            2'b10: colorOut = bgArr[2];
            default: colorOut = nibLow;
          endcase
        end
      end
      MODE_ECT: colorOut = hiBit ? nibQ : bgArr[matQ[MAT_W-1 -: 2]];
      MODE_HBM: colorOut = hiBit ? matHi : matLo;
      MODE_MBM: begin
        unique case (pairCode)
          2'b00: colorOut = bgArr[0];
          2'b01: colorOut = matHi;
          2'b10: colorOut = matLo;
          default: colorOut = nibQ;
        endcase
      end
      default: colorOut = '0;
    endcase
  end

  always_comb begin
    if (mode == MODE_HBM && !fgOut)
      p_hbm_clear_r7: assert (colorOut == matLo);
    if (mode == MODE_MCT && pairMode && fgOut)
      p_mct_fg_r4: assert (colorOut == bgArr[2] || colorOut == nibLow);
  end

endmodule

// File: rtl/bgDecData.sv
module bgDecData
  import bgdec_pkg::*;
#(
  parameter int COLOR_W = 4,
  parameter int CELL_W  = 8,
  localparam int MAT_W  = 2 * COLOR_W,
  localparam int BG_W   = NUM_BG * COLOR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  decStrobe_t         strb,
  input  logic [MAT_W-1:0]   matrixByte,
  input  logic [COLOR_W-1:0] colorNib,
  input  logic [CELL_W-1:0]  glyphByte,
  input  logic [BG_W-1:0]    bgColors,
  output logic [COLOR_W-1:0] pixColor,
  output logic               pixFg
);

  logic [CELL_W-1:0]  shReg;
  logic [MAT_W-1:0]   matQ;
  logic [COLOR_W-1:0] nibQ;
  logic [BG_W-1:0]    bgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      matQ  <= '0;
      nibQ  <= '0;
      bgQ   <= '0;
    end else if (strb.load) begin
      shReg <= glyphByte;
      matQ  <= matrixByte;
      nibQ  <= colorNib;
      bgQ   <= bgColors;
    end else if (strb.shiftOne) begin
      shReg <= shReg << 1;
    end else if (strb.shiftTwo) begin
      shReg <= shReg << 2;
    end
  end

  bgColorSel #(.COLOR_W(COLOR_W)) u_sel (
    .mode     (strb.mode),
    .pairMode (strb.pairMode),
    .hiBit    (shReg[CELL_W-1]),
    .pairCode (shReg[CELL_W-1 -: 2]),
    .matQ     (matQ),
    .nibQ     (nibQ),
    .bgQ      (bgQ),
    .colorOut (pixColor),
    .fgOut    (pixFg)
  );

  p_pair_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pairMode && !strb.load && !strb.shiftTwo) |=> $stable(shReg));

endmodule

// File: rtl/bgPixelDecoder.sv
module bgPixelDecoder
  import bgdec_pkg::*;
#(
  parameter int COLOR_W = 4,
  parameter int CELL_W  = 8,
  localparam int MAT_W  = 2 * COLOR_W,
  localparam int BG_W   = NUM_BG * COLOR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cellStart,
  input  logic [MAT_W-1:0]   matrixByte,
  input  logic [COLOR_W-1:0] colorNib,
  input  logic [CELL_W-1:0]  glyphByte,
  input  logic               modeExt,
  input  logic               modeBmp,
  input  logic               modeMc,
  input  logic [BG_W-1:0]    bgColors,
  output logic [COLOR_W-1:0] pixColor,
  output logic               pixFg
);

  decStrobe_t strb;

  bgDecCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cellStart (cellStart),
    .modeExt   (modeExt),
    .modeBmp   (modeBmp),
    .modeMc    (modeMc),
    .nibTop    (colorNib[COLOR_W-1]),
    .strb      (strb)
  );

  bgDecData #(.COLOR_W(COLOR_W), .CELL_W(CELL_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .matrixByte (matrixByte),
    .colorNib   (colorNib),
    .glyphByte  (glyphByte),
    .bgColors   (bgColors),
    .pixColor   (pixColor),
    .pixFg      (pixFg)
  );

  p_bad_black_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cellStart && modeExt && (modeBmp || modeMc)) |=> (pixColor == '0));

endmodule

// File: tb/sim_bgPixelDecoder.sv
`timescale 1ns/1ps
module sim_bgPixelDecoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cellStart = 1'b0;
  logic [7:0] matrixByte = '0;
  logic [3:0] colorNib = '0;
  logic [7:0] glyphByte = '0;
  logic       modeExt = 1'b0;
  logic       modeBmp = 1'b0;
  logic       modeMc = 1'b0;
  logic [15:0] bgColors = '0;
  logic [3:0] pixColor;
  logic       pixFg;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bgPixelDecoder u0 (
    .clk(clk), .rstN(rstN), .cellStart(cellStart), .matrixByte(matrixByte),
    .colorNib(colorNib), .glyphByte(glyphByte), .modeExt(modeExt),
    .modeBmp(modeBmp), .modeMc(modeMc), .bgColors(bgColors),
    .pixColor(pixColor), .pixFg(pixFg)
  );

  function automatic logic [4:0] refPix(input logic e, input logic b, input logic m,
      input logic [7:0] mat, input logic [3:0] nib, input logic [7:0] gl,
      input logic [15:0] bg, input int i);
    logic pair, hb, fg;
    logic [1:0] pc;
    logic [3:0] c;
    pair = m && (b || nib[3]);
    hb = (i < 8) ? gl[7-i] : 1'b0;
    pc = (i < 8) ? {gl[7-2*(i/2)], gl[6-2*(i/2)]} : 2'b00;
    fg = pair ? pc[1] : hb;
    if (e && (b || m)) c = 4'd0;
    else if (e) c = hb ? nib : bg[mat[7:6]*4 +: 4];
    else if (!b && !pair) c = hb ? nib : bg[3:0];
    else if (!b) begin
      case (pc)
        2'b00: c = bg[3:0];
        2'b01: c = bg[7:4];
        2'b10: c = bg[11:8];
        default: c = {1'b0, nib[2:0]};
      endcase
    end else if (!m) c = hb ? mat[7:4] : mat[3:0];
    else begin
      case (pc)
        2'b00: c = bg[3:0];
        2'b01: c = mat[7:4];
        2'b10: c = mat[3:0];
        default: c = nib;
      endcase
    end
    return {fg, c};
  endfunction

  function automatic string modeTag(input logic e, input logic b, input logic m,
      input logic [3:0] nib);
    if (e && (b || m)) return "R9";
    if (e) return "R6";
    if (b && m) return "R8/R10";
    if (b) return "R7";
    if (m && nib[3]) return "R4/R10";
    if (m) return "R5";
    return "R3";
  endfunction

  task automatic checkPix(input string tag, input logic [4:0] exp);
    checks++;
    if (pixColor !== exp[3:0]) begin
      failures++;
      $display("FAIL %s color actual=%0d expected=%0d", tag, pixColor, exp[3:0]);
    end
    checks++;
    if (pixFg !== exp[4]) begin
      failures++;
      $display("FAIL R11 (%s) fg actual=%0d expected=%0d", tag, pixFg, exp[4]);
    end
  endtask

  // called at a negedge; drives a cell and checks len dots
  task automatic runCell(input logic e, input logic b, input logic m,
      input logic [7:0] mat, input logic [3:0] nib, input logic [7:0] gl,
      input logic [15:0] bg, input int len, input bit scramble);
    string tag;
    tag = modeTag(e, b, m, nib);
    modeExt = e; modeBmp = b; modeMc = m;
    matrixByte = mat; colorNib = nib; glyphByte = gl; bgColors = bg;
    cellStart = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      cellStart = 1'b0;
      checkPix((i >= 8) ? "R2" : tag, refPix(e, b, m, mat, nib, gl, bg, i));
      if (scramble) begin
        // R2: inputs between cell starts are ignored
        matrixByte = 8'($urandom); colorNib = 4'($urandom);
        glyphByte = 8'($urandom); bgColors = 16'($urandom);
        {modeExt, modeBmp, modeMc} = 3'($urandom);
      end
    end
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkPix("R1", 5'b0_0000);
    @(negedge clk);
    checkPix("R1", 5'b0_0000);

    // R3 standard text, run past the end (R2)
    runCell(0, 0, 0, 8'h5A, 4'hC, 8'b1011_0010, 16'h4321, 10, 0);
    // R4 multicolor text with pair decoding, all four codes
    runCell(0, 0, 1, 8'h11, 4'hD, 8'b0001_1011, 16'hFEDA, 10, 1);
    // R5 multicolor text, attribute bit 3 clear
    runCell(0, 0, 1, 8'h22, 4'h6, 8'b1100_1010, 16'h9876, 8, 0);
    // R6 extended-color text, each background select
    for (int k = 0; k < 4; k++)
      runCell(1, 0, 0, {2'(k), 6'h15}, 4'h7, 8'b0110_1001, 16'hBA98, 8, 1);
    // R7 hi-res bitmap
    runCell(0, 1, 0, 8'hE3, 4'h1, 8'b1001_0110, 16'h1111, 9, 0);
    // R8 multicolor bitmap, all codes
    runCell(0, 1, 1, 8'h9C, 4'hF, 8'b1110_0100, 16'h5552, 10, 0);
    // R9 illegal modes
    runCell(1, 0, 1, 8'hFF, 4'hF, 8'b1101_1011, 16'hFFFF, 8, 0);
    runCell(1, 1, 0, 8'hFF, 4'hF, 8'b1010_0101, 16'hFFFF, 8, 0);
    runCell(1, 1, 1, 8'hFF, 4'hF, 8'b0111_1000, 16'hFFFF, 8, 0);
    // R10: pair cell cut short on an odd dot, followed by another pair cell
    runCell(0, 1, 1, 8'h3A, 4'h2, 8'b0110_1101, 16'h0007, 3, 0);
    runCell(0, 1, 1, 8'hA3, 4'h9, 8'b1001_1100, 16'h000B, 8, 0);

    for (int n = 0; n < 600; n++) begin
      runCell(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
              4'($urandom), 8'($urandom), 16'($urandom),
              8 + int'($urandom % 3), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule